// File: doc/BRIEF.md
# Performance Monitor Counter Bank

This block keeps ten 48-bit event counters for a processor core. Each is reached through a simple single-cycle register port: software can load a counter, read it back, and program the controls. Counter 0 is tied to a cycle strobe and counter 1 to an instruction-retire strobe. Counters 2 to 9 each pick one of 256 event strobes through an 8-bit code. A counter advances only when three conditions hold:
- its enable bit is set;
- the enable for the current privilege level (user or kernel) is set;
- its selected event strobe is high in that cycle.

When a counter's bit 47 rises, the counter's overflow flag is set and stays set. An interrupt can be raised on one of three output lines, picked by a mode field. Once raised, a software-cleared active flag blocks any further interrupt. An optional stop bit freezes every counter while that flag is set.

Register map (4-bit address, 64-bit data). Reads are combinational, and writes take effect at the clock edge.

| Address | Register |
|---------|----------|
| 0 to 9 | Counters, zero-extended on read |
| 10 | Control A |
| 11 | Control B |
| 12 | Event select low |
| 13 | Event select high |
| 14 | Overflow status |
| 15 | Unmapped, reads zero |

Top module: `perf_counter_bank`

## Requirements
- R1: After reset, every address reads zero and all three interrupt outputs are low. Address 15 always reads zero.
- R2: A write to address n (0 to 9) loads bits 47:0 into counter n at the next edge, and a read returns the counter zero-extended. A write wins over an increment of the same counter in the same cycle. Counters wrap from all-ones to zero.
- R3: Counter 0 counts cycles where `evtCycle` is high and counter 1 counts cycles where `evtInstr` is high. The event-select registers have no effect on either counter.
- R4: Counter 2+k (k = 0 to 3) takes its code from bits 8k+7:8k of address 12. Counter 6+k takes its code from bits 8k+7:8k of address 13. Code c selects `evtLines[c]`. Both select registers keep bits 31:0 only.
- R5: In control A, the count enables for counters 0 to 7 are bits 7:0 and those for counters 8 and 9 are bits 33:32. A counter whose enable is clear does not change.
- R6: In control B, the user enables are bits 15:8 (counters 0 to 7) and 41:40 (counters 8 and 9). The kernel enables are bits 23:16 and 49:48. `privKernel` picks which set applies in a given cycle. Unused control bits read zero.
- R7: When an increment moves a counter's bit 47 from 0 to 1, status bit n (of bits 9:0 at address 14) is set. Writing a 1 to that bit clears it, but a set in the same cycle wins over the clear.
- R8: Control A bits 10:8 pick the interrupt mode: 1 drives `irqPmi`, 3 drives `irqHalt`, 4 drives `irqFiq`. Values 0, 2 and 5 to 7 raise nothing. A line is high for one cycle when the mode is valid, some counter has both its status flag and its interrupt enable set, and the active flag (bit 11) is clear.
- R9: The interrupt enables for counters 0 to 7 are control A bits 19:12, and those for counters 8 and 9 are bits 45:44.
- R10: The cycle after an interrupt is raised, bit 11 reads one. It returns to zero only when software writes control A with bit 11 at zero. If the condition still holds after that, the interrupt is raised again.
- R11: While control A bit 20 and bit 11 are both set, no counter increments. Software writes to the counters still take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWdata | input | 64 | Write data |
| regRdata | output | 64 | Read data for `regAddr` |
| privKernel | input | 1 | 1 = kernel level, 0 = user level |
| evtCycle | input | 1 | Cycle strobe for counter 0 |
| evtInstr | input | 1 | Retired-instruction strobe for counter 1 |
| evtLines | input | 256 | Event strobes selectable by code |
| irqPmi | output | 1 | Interrupt pulse, mode 1 |
| irqHalt | output | 1 | Halt request pulse, mode 3 |
| irqFiq | output | 1 | Fast interrupt pulse, mode 4 |

## Verification
The hardest state to reach is a counter crossing bit 47 while the interrupt, the active flag and the stop bit interact. From reset this would take 2^47 events. The stimulus therefore loads counters just below the boundary, with one preload at all-ones to cover the wrap.

The test then does the following:
- enables the event strobes so the crossing happens within a few cycles;
- steps through all eight mode values;
- rewrites control A to clear the active flag while the status flag is still pending, so the interrupt must fire again;
- sets the stop bit to check that counting halts until the flag is cleared.

A random phase then mixes writes, privilege changes and event patterns against the reference model.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int NUM_CNT   = 10;
  localparam int CNT_W     = 48;
  localparam int OVF_BIT   = CNT_W - 1;
  localparam int EVT_W     = 8;
  localparam int NUM_EVT   = 1 << EVT_W;
  localparam int REG_W     = 64;
  localparam int ADDR_W    = 4;
  localparam int SEL_W     = 32;
  localparam int FIXED_CNT = 2;
  localparam int LANES     = SEL_W / EVT_W;
  localparam int LO_CNT    = 8;
  localparam int MODE_W    = 3;

  localparam logic [ADDR_W-1:0] A_CTRLA = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] A_CTRLB = ADDR_W'(11);
  localparam logic [ADDR_W-1:0] A_SELLO = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_SELHI = ADDR_W'(13);
  localparam logic [ADDR_W-1:0] A_STS   = ADDR_W'(14);

  // control A layout
  localparam int EN_LO    = 0;
  localparam int EN_HI    = 32;
  localparam int IE_LO    = 12;
  localparam int IE_HI    = 44;
  localparam int MODE_LSB = 8;
  localparam int ACT_BIT  = 11;
  localparam int STOP_BIT = 20;
  // control B layout
  localparam int USR_LO = 8;
  localparam int USR_HI = 40;
  localparam int KRN_LO = 16;
  localparam int KRN_HI = 48;

  typedef enum logic [MODE_W-1:0] {
    IRQ_OFF  = 3'd0,
    IRQ_PMI  = 3'd1,
    IRQ_HALT = 3'd3,
    IRQ_FIQ  = 3'd4
  } irqMode_e;

  function automatic int fieldPos(int lo, int hi, int idx);
    return (idx < LO_CNT) ? lo + idx : hi + idx - LO_CNT;
  endfunction

  function automatic logic [REG_W-1:0] ctrlAMask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      m[fieldPos(EN_LO, EN_HI, i)] = 1'b1;
      m[fieldPos(IE_LO, IE_HI, i)] = 1'b1;
    end
    m[MODE_LSB +: MODE_W] = '1;
    m[ACT_BIT]  = 1'b1;
    m[STOP_BIT] = 1'b1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] ctrlBMask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      m[fieldPos(USR_LO, USR_HI, i)] = 1'b1;
      m[fieldPos(KRN_LO, KRN_HI, i)] = 1'b1;
    end
    return m;
  endfunction

  typedef struct packed {
    logic [NUM_CNT-1:0]            wrSel;
    logic [CNT_W-1:0]              wrData;
    logic [NUM_CNT-1:0]            cntGo;
    logic [NUM_CNT-1:0][EVT_W-1:0] evtCode;
  } strobe_t;
endpackage

// File: rtl/pmc_datapath.sv
module pmc_datapath
  import pmc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strb,
  input  logic                          evtCycle,
  input  logic                          evtInstr,
  input  logic [NUM_EVT-1:0]            evtLines,
  output logic [NUM_CNT-1:0][CNT_W-1:0] cntVal,
  output logic [NUM_CNT-1:0]            ovfHit
);
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic             evtHit;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cntNext;

    if (i == 0) begin : g_cyc
      assign evtHit = evtCycle;
    end else if (i == 1) begin : g_ins
      assign evtHit = evtInstr;
    end else begin : g_sel
      assign evtHit = evtLines[strb.evtCode[i]];
    end

    assign cntNext = cnt + CNT_W'(1);
    assign ovfHit[i] = !strb.wrSel[i] && strb.cntGo[i] && evtHit &&
                       !cnt[OVF_BIT] && cntNext[OVF_BIT];
    assign cntVal[i] = cnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          cnt <= '0;
      else if (strb.wrSel[i])             cnt <= strb.wrData;
      else if (strb.cntGo[i] && evtHit)   cnt <= cntNext;
    end

    // R2
    wr_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.wrSel[i] |=> cnt == $past(strb.wrData));
  end
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWrEn,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [REG_W-1:0]              regWdata,
  output logic [REG_W-1:0]              regRdata,
  input  logic                          privKernel,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] cntVal,
  input  logic [NUM_CNT-1:0]            ovfHit,
  output strobe_t                       strb,
  output logic                          irqPmi,
  output logic                          irqHalt,
  output logic                          irqFiq
);
  localparam logic [REG_W-1:0] MASK_A = ctrlAMask();
  localparam logic [REG_W-1:0] MASK_B = ctrlBMask();

  logic [REG_W-1:0]   ctrlA, ctrlB;
  logic [SEL_W-1:0]   selLo, selHi;
  logic [NUM_CNT-1:0] ovfSts, clrVec;
  logic [NUM_CNT-1:0] enVec, ieVec, usrVec, krnVec;
  logic [MODE_W-1:0]  modeRaw;
  logic               modeOk, pending, fire, freeze;

  always_comb begin
    for (int i = 0; i < NUM_CNT; i++) begin
      enVec[i]  = ctrlA[fieldPos(EN_LO, EN_HI, i)];
      ieVec[i]  = ctrlA[fieldPos(IE_LO, IE_HI, i)];
      usrVec[i] = ctrlB[fieldPos(USR_LO, USR_HI, i)];
      krnVec[i] = ctrlB[fieldPos(KRN_LO, KRN_HI, i)];
    end
  end

  assign freeze  = ctrlA[STOP_BIT] && ctrlA[ACT_BIT];
  assign modeRaw = ctrlA[MODE_LSB +: MODE_W];
  assign modeOk  = (modeRaw == IRQ_PMI) || (modeRaw == IRQ_HALT) || (modeRaw == IRQ_FIQ);
  assign pending = |(ovfSts & ieVec);
  assign fire    = modeOk && pending && !ctrlA[ACT_BIT];
  assign irqPmi  = fire && (modeRaw == IRQ_PMI);
  assign irqHalt = fire && (modeRaw == IRQ_HALT);
  assign irqFiq  = fire && (modeRaw == IRQ_FIQ);
  assign clrVec  = (regWrEn && regAddr == A_STS) ? regWdata[NUM_CNT-1:0] : '0;

  always_comb begin
    strb.wrData = regWdata[CNT_W-1:0];
    for (int i = 0; i < NUM_CNT; i++) begin
      strb.wrSel[i] = regWrEn && (regAddr == ADDR_W'(i));
      strb.cntGo[i] = enVec[i] && (privKernel ? krnVec[i] : usrVec[i]) && !freeze;
      if (i < FIXED_CNT)
        strb.evtCode[i] = '0;
      else if ((i - FIXED_CNT) < LANES)
        strb.evtCode[i] = selLo[((i - FIXED_CNT) % LANES) * EVT_W +: EVT_W];
      else
        strb.evtCode[i] = selHi[((i - FIXED_CNT) % LANES) * EVT_W +: EVT_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlA  <= '0;
      ctrlB  <= '0;
      selLo  <= '0;
      selHi  <= '0;
      ovfSts <= '0;
    end else begin
      if (regWrEn) begin
        case (regAddr)
          A_CTRLA: ctrlA <= regWdata & MASK_A;
          A_CTRLB: ctrlB <= regWdata & MASK_B;
          A_SELLO: selLo <= regWdata[SEL_W-1:0];
          A_SELHI: selHi <= regWdata[SEL_W-1:0];
          default: ;
        endcase
      end
      if (fire) ctrlA[ACT_BIT] <= 1'b1;
      ovfSts <= (ovfSts & ~clrVec) | ovfHit;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_CTRLA: regRdata = ctrlA;
      A_CTRLB: regRdata = ctrlB;
      A_SELLO: regRdata = REG_W'(selLo);
      A_SELHI: regRdata = REG_W'(selHi);
      A_STS:   regRdata = REG_W'(ovfSts);
      default: begin
        for (int i = 0; i < NUM_CNT; i++)
          if (regAddr == ADDR_W'(i)) regRdata = REG_W'(cntVal[i]);
      end
    endcase
  end

  // R7
  sts_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ovfSts) & ~ovfSts & ~$past(clrVec)) == '0);
  // R10
  irq_sets_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqPmi || irqHalt || irqFiq) |=> ctrlA[ACT_BIT]);
  // R10
  active_sw_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrlA[ACT_BIT]) |-> $past(regWrEn && regAddr == A_CTRLA));
  // R11
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (freeze && !regWrEn) |=> $stable(cntVal));
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import pmc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [REG_W-1:0]     regWdata,
  output logic [REG_W-1:0]     regRdata,
  input  logic                 privKernel,
  input  logic                 evtCycle,
  input  logic                 evtInstr,
  input  logic [NUM_EVT-1:0]   evtLines,
  output logic                 irqPmi,
  output logic                 irqHalt,
  output logic                 irqFiq
);
  strobe_t                       strb;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntVal;
  logic [NUM_CNT-1:0]            ovfHit;

  pmc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .privKernel(privKernel),
    .cntVal(cntVal), .ovfHit(ovfHit), .strb(strb),
    .irqPmi(irqPmi), .irqHalt(irqHalt), .irqFiq(irqFiq)
  );

  pmc_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .evtCycle(evtCycle),
    .evtInstr(evtInstr), .evtLines(evtLines), .cntVal(cntVal), .ovfHit(ovfHit)
  );
endmodule

// File: tb/perf_counter_bank_tb_top.sv
`timescale 1ns/1ps
module perf_counter_bank_tb_top;
  localparam longint unsigned M48   = 64'h0000_FFFF_FFFF_FFFF;
  localparam longint unsigned MASKA = 64'h0000_3003_001F_FFFF;
  localparam longint unsigned MASKB = 64'h0003_0300_00FF_FF00;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [63:0] regWdata = '0;
  logic [63:0] regRdata;
  logic privKernel = 1'b0;
  logic evtCycle = 1'b0;
  logic evtInstr = 1'b0;
  logic [255:0] evtLines = '0;
  logic irqPmi, irqHalt, irqFiq;

  int compared = 0;
  int mismatched = 0;
  string tag = "R1";

  longint unsigned mCnt [10];
  longint unsigned mA, mB, mLo, mHi;
  logic [9:0] mSts;

  always #2.5 clk = ~clk;

  perf_counter_bank dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .privKernel(privKernel),
    .evtCycle(evtCycle), .evtInstr(evtInstr), .evtLines(evtLines),
    .irqPmi(irqPmi), .irqHalt(irqHalt), .irqFiq(irqFiq)
  );

  function automatic int pos(int lo, int hi, int i);
    return (i < 8) ? lo + i : hi + i - 8;
  endfunction

  function automatic longint unsigned mRead(int a);
    if (a < 10) return mCnt[a];
    case (a)
      10: return mA;
      11: return mB;
      12: return mLo;
      13: return mHi;
      14: return {54'd0, mSts};
      default: return 0;
    endcase
  endfunction

  function automatic logic [2:0] mIrq();
    int mode = int'(mA[10:8]);
    bit pend = 0;
    for (int i = 0; i < 10; i++)
      if (mSts[i] && mA[pos(12, 44, i)]) pend = 1;
    if (!pend || mA[11]) return 3'b000;
    if (mode == 1) return 3'b001;
    if (mode == 3) return 3'b010;
    if (mode == 4) return 3'b100;
    return 3'b000;
  endfunction

  task automatic mStep();
    logic [2:0] f = mIrq();
    bit frz = mA[20] && mA[11];
    logic [9:0] setv = '0;
    for (int i = 0; i < 10; i++) begin
      int code;
      bit ev, en, pr;
      longint unsigned nxt;
      if (i < 6) code = int'((mLo >> ((i - 2) * 8)) & 255);
      else       code = int'((mHi >> ((i - 6) * 8)) & 255);
      ev = (i == 0) ? evtCycle : (i == 1) ? evtInstr : evtLines[code];
      en = mA[pos(0, 32, i)];
      pr = privKernel ? mB[pos(16, 48, i)] : mB[pos(8, 40, i)];
      if (regWrEn && int'(regAddr) == i) mCnt[i] = regWdata & M48;
      else if (en && pr && ev && !frz) begin
        nxt = (mCnt[i] + 1) & M48;
        if (nxt[47] && !mCnt[i][47]) setv[i] = 1'b1;
        mCnt[i] = nxt;
      end
    end
    if (regWrEn && regAddr == 4'd14) mSts = mSts & ~regWdata[9:0];
    mSts = mSts | setv;
    if (regWrEn) begin
      case (int'(regAddr))
        10: mA  = regWdata & MASKA;
        11: mB  = regWdata & MASKB;
        12: mLo = regWdata & 64'hFFFF_FFFF;
        13: mHi = regWdata & 64'hFFFF_FFFF;
        default: ;
      endcase
    end
    if (f != 0) mA[11] = 1'b1;
  endtask

  task automatic tick();
    longint unsigned er;
    logic [2:0] ei;
    #1;
    er = mRead(int'(regAddr));
    ei = mIrq();
    compared++;
    if (regRdata !== er) begin
      mismatched++;
      $display("FAIL %s: read addr %0d actual %h expected %h", tag, regAddr, regRdata, er);
    end
    compared++;
    if ({irqFiq, irqHalt, irqPmi} !== ei) begin
      mismatched++;
      $display("FAIL %s: irq {fiq,halt,pmi} actual %b expected %b", tag,
               {irqFiq, irqHalt, irqPmi}, ei);
    end
    @(posedge clk);
    mStep();
    @(negedge clk);
  endtask

  task automatic wr(int a, longint unsigned d);
    regWrEn = 1'b1; regAddr = 4'(a); regWdata = d;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic randEvt();
    evtCycle = 1'($urandom);
    evtInstr = 1'($urandom);
    for (int j = 0; j < 8; j++) evtLines[j*32 +: 32] = $urandom;
  endtask

  task automatic run(int n, bit rnd);
    for (int k = 0; k < n; k++) begin
      regAddr = 4'(k % 16);
      if (rnd) randEvt();
      tick();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 10; i++) mCnt[i] = 0;
    mA = 0; mB = 0; mLo = 0; mHi = 0; mSts = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    tag = "R1"; run(16, 0);

    tag = "R2";
    for (int i = 0; i < 10; i++) wr(i, 64'hABCD_0000_1234_5600 + longint'(i));
    run(16, 0);
    wr(10, 64'h1); wr(11, 64'hFFFF_FFFF_FFFF_FFFF);
    evtCycle = 1'b1;
    wr(0, 64'h55); wr(0, 64'h77); run(4, 0);
    wr(0, M48); run(3, 0);

    tag = "R3";
    wr(12, 64'hFFFF_FFFF); wr(13, 64'hFFFF_FFFF); wr(10, 64'h3);
    run(40, 1);

    tag = "R4";
    wr(12, 64'h4433_2211); wr(13, 64'hFF77_6655); wr(10, 64'h3_0000_00FF);
    run(60, 1);
    evtLines = '0; evtLines[8'h22] = 1'b1; evtLines[8'hFF] = 1'b1; run(16, 0);

    tag = "R5";
    wr(10, 64'h3_0000_0008); run(30, 1);
    wr(10, 64'h1_0000_0050); run(30, 1);

    tag = "R6";
    wr(10, 64'h3_0000_00FF); wr(11, 64'h0001_0200_A50F_F000);
    for (int k = 0; k < 40; k++) begin
      privKernel = 1'($urandom); regAddr = 4'(k % 16); randEvt(); tick();
    end
    wr(11, 64'hFFFF_FFFF_FFFF_FFFF); run(16, 0);

    tag = "R7";
    evtLines = '1; evtCycle = 1'b0; evtInstr = 1'b0;
    wr(4, 64'h7FFF_FFFF_FFFD); run(8, 0);
    wr(14, 64'h3EF); run(4, 0);
    wr(14, 64'h10); run(4, 0);
    wr(5, 64'h7FFF_FFFF_FFFF); wr(14, 64'h20); run(4, 0);

    tag = "R8";
    for (int m = 0; m < 8; m++) begin
      wr(10, 64'h3_0001_00FF | (longint'(m) << 8));
      wr(14, 64'h3FF); wr(4, 64'h7FFF_FFFF_FFFE);
      regAddr = 4'd10; tick(); tick(); tick(); run(4, 0);
    end

    tag = "R9";
    wr(10, 64'h1000_0000_0000 | 64'h3_0000_0100); wr(14, 64'h3FF);
    wr(8, 64'h7FFF_FFFF_FFFE); run(6, 0);
    wr(10, 64'h1000_0000_0100 | 64'h1_0000_0000); wr(14, 64'h3FF);
    wr(9, 64'h7FFF_FFFF_FFFE); run(6, 0);

    tag = "R10";
    wr(10, 64'h3_0001_01FF); wr(14, 64'h3FF);
    wr(4, 64'h7FFF_FFFF_FFFE); run(5, 0);
    wr(10, 64'h3_0001_01FF); regAddr = 4'd10; tick(); tick(); run(4, 0);
    wr(14, 64'h10); wr(10, 64'h3_0001_01FF); run(4, 0);

    tag = "R11";
    wr(10, 64'h3_0011_01FF); wr(3, 64'h7FFF_FFFF_FFFE); run(12, 0);
    wr(2, 64'h123); run(6, 0);
    wr(14, 64'h3FF); wr(10, 64'h3_0011_01FF); run(8, 0);

    tag = "RND";
    for (int k = 0; k < 400; k++) begin
      privKernel = 1'($urandom);
      randEvt();
      if (($urandom % 4) == 0) begin
        int a = int'($urandom % 16);
        longint unsigned d = {$urandom, $urandom};
        if (a < 10 && ($urandom % 2)) d = 64'h7FFF_FFFF_FFF0 | (d & 64'hF);
        wr(a, d);
      end else begin
        regAddr = 4'($urandom % 16); tick();
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule